// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide programming interface of a timer with three counting channels. A host reaches it through a 2-bit address with separate 8-bit write and read data ports. Addresses 0, 1 and 2 each reach the count register of one channel, and address 3 accepts control words. The counting engines are outside this block. Each channel hands this block its live 16-bit count and its output bit. In return the block gives each channel a one-cycle load strobe with a 16-bit initial count, plus the channel's mode and BCD setting.

A control word does one of three things. It can reprogram one channel's access type, mode and BCD flag. It can freeze one channel's count. As a read-back command, it can freeze count and/or status for any set of channels. Each channel holds its frozen count and its frozen status byte separately. A read returns these in a fixed priority order and releases each one after it has been read out. Each channel keeps separate byte toggles for writes and for live reads, so 16-bit values can be moved as two bytes.

Per channel, the write toggle has two states, WR_FIRST and WR_SECOND. A word write moves it from WR_FIRST to WR_SECOND, and the next word write moves it back and loads the count. The live-read toggle likewise moves between RD_FIRST and RD_SECOND on each live word read. The count snapshot has four states:
- CL_EMPTY: no snapshot is held.
- CL_LSB: a count is frozen while the access type is LSB only. A read returns to CL_EMPTY.
- CL_MSB: a count is frozen while the access type is MSB only, or the low byte of a word snapshot has already been read. A read returns to CL_EMPTY.
- CL_WORD: a count is frozen while the access type is word. A read moves to CL_MSB.

Top module: `tmr_cmd_front`

## Requirements
- R1: After reset, every channel is in word access with mode 0 and BCD 0, and holds no snapshot. Both of its toggles are on the first byte, and `load_stb` is 0.
- R2: A control write (address 3) with bits 7:6 equal to c (0 to 2) and bits 5:4 nonzero sets channel c's access type to bits 5:4, its mode to bits 3:1 and its BCD flag to bit 0. The new mode and BCD appear on `cfg_mode`/`cfg_bcd` in the next cycle. Access codes are 1 = LSB only, 2 = MSB only, 3 = low byte then high byte.
- R3: A control write with bits 5:4 equal to 0 freezes channel c's live count and leaves its mode, BCD and access type unchanged.
- R4: A control write with bits 7:6 equal to 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. For each selected channel, bit 5 low freezes the count and bit 4 low freezes the status.
- R5: A count-freeze or status-freeze request for a channel has no effect while that channel still holds an unread snapshot of the same kind.
- R6: The frozen status byte is {output, 0, access[1:0], mode[2:0], bcd}, from bit 7 down to bit 0, taken at the moment of the freeze.
- R7: A read of channel c returns the frozen status if one is held, otherwise the frozen count if one is held, otherwise the live count. Each frozen item is released once it has been fully read.
- R8: A frozen count is read as follows. In LSB-only access, one read gives the low byte. In MSB-only access, one read gives the high byte. In word access, the first read gives the low byte and the second gives the high byte.
- R9: Count writes work as follows. An LSB-only write loads {0x00, byte}. An MSB-only write loads {byte, 0x00}. In word access, the first byte is held and the second byte loads {second, first}.
- R10: A live read in word access alternates between low byte and high byte. The read toggle is independent of the write toggle. Live reads in LSB-only access return the low byte, and in MSB-only access the high byte.
- R11: A read of address 3 returns 0x00.
- R12: Writing a new control word with nonzero access to a channel puts both of that channel's toggles back on the first byte. Any byte held from an earlier word write is discarded.
- R13: `load_stb[c]` pulses for exactly one cycle. It is high in the cycle after the write that completes a count, with `load_val` holding that count, and at most one channel strobes at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe; advances read state at the clock edge |
| addr | input | 2 | 0 to 2 select a channel count, 3 selects control |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| live_cnt | input | 48 | Live count of each channel, channel c in bits 16c+15:16c |
| live_out | input | 3 | Output bit of each channel |
| load_stb | output | 3 | One-cycle initial-count load strobe per channel |
| load_val | output | 48 | Initial count per channel, channel c in bits 16c+15:16c |
| cfg_mode | output | 9 | Mode of each channel, channel c in bits 3c+2:3c |
| cfg_bcd | output | 3 | BCD flag of each channel |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. Under that assumption, a freeze request and a byte read never reach the same channel's snapshot state together. The stimulus issues exactly one read or one write per cycle, with a quiet cycle between operations.

The live counts and output bits are held steady across each freeze. They are changed only between operations, so it is possible to tell whether a later request was ignored.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LSB   = 2'd1,
        ACC_MSB   = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic {
        WR_FIRST  = 1'b0,
        WR_SECOND = 1'b1
    } wr_tog_e;

    typedef enum logic {
        RD_FIRST  = 1'b0,
        RD_SECOND = 1'b1
    } rd_tog_e;

    typedef enum logic [1:0] {
        CL_EMPTY = 2'd0,
        CL_LSB   = 2'd1,
        CL_MSB   = 2'd2,
        CL_WORD  = 2'd3
    } cl_e;
endpackage

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_regs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_stb,
    input  acc_e                  cfg_acc,
    input  logic [MODE_W-1:0]     cfg_mode_in,
    input  logic                  cfg_bcd_in,
    input  logic                  cnt_req,
    input  logic                  sts_req,
    input  logic                  wr_stb,
    input  logic                  rd_stb,
    input  logic [BYTE_W-1:0]     wr_byte,
    input  logic [CNT_W-1:0]      live_cnt,
    input  logic                  live_out,
    output logic [BYTE_W-1:0]     rd_byte,
    output logic                  load_stb,
    output logic [CNT_W-1:0]      load_val,
    output logic [MODE_W-1:0]     mode_q,
    output logic                  bcd_q
);
    acc_e                acc_q,  acc_d;
    logic [MODE_W-1:0]   mode_d;
    logic                bcd_d;
    wr_tog_e             wtog_q, wtog_d;
    rd_tog_e             rtog_q, rtog_d;
    logic [BYTE_W-1:0]   held_q, held_d;
    cl_e                 cl_q,   cl_d;
    logic [CNT_W-1:0]    clv_q,  clv_d;
    logic                sf_q,   sf_d;
    logic [BYTE_W-1:0]   sv_q,   sv_d;
    logic                ld_d;
    logic [CNT_W-1:0]    ldv_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= ACC_WORD;
            mode_q   <= '0;
            bcd_q    <= 1'b0;
            wtog_q   <= WR_FIRST;
            rtog_q   <= RD_FIRST;
            held_q   <= '0;
            cl_q     <= CL_EMPTY;
            clv_q    <= '0;
            sf_q     <= 1'b0;
            sv_q     <= '0;
            load_stb <= 1'b0;
            load_val <= '0;
        end else begin
            acc_q    <= acc_d;
            mode_q   <= mode_d;
            bcd_q    <= bcd_d;
            wtog_q   <= wtog_d;
            rtog_q   <= rtog_d;
            held_q   <= held_d;
            cl_q     <= cl_d;
            clv_q    <= clv_d;
            sf_q     <= sf_d;
            sv_q     <= sv_d;
            load_stb <= ld_d;
            load_val <= ldv_d;
        end
    end

    // next state and read data
    always_comb begin
        acc_d   = acc_q;
        mode_d  = mode_q;
        bcd_d   = bcd_q;
        wtog_d  = wtog_q;
        rtog_d  = rtog_q;
        held_d  = held_q;
        cl_d    = cl_q;
        clv_d   = clv_q;
        sf_d    = sf_q;
        sv_d    = sv_q;
        ld_d    = 1'b0;
        ldv_d   = load_val;
        rd_byte = '0;

        if (cfg_stb) begin
            acc_d  = cfg_acc;
            mode_d = cfg_mode_in;
            bcd_d  = cfg_bcd_in;
            wtog_d = WR_FIRST;
            rtog_d = RD_FIRST;
        end
        if (cnt_req && cl_q == CL_EMPTY) begin
            cl_d  = cl_e'(acc_q);
            clv_d = live_cnt;
        end
        if (sts_req && !sf_q) begin
            sf_d = 1'b1;
            sv_d = {live_out, 1'b0, acc_q, mode_q, bcd_q};
        end

        if (wr_stb) begin
            unique case (acc_q)
                ACC_LSB: begin
                    ld_d  = 1'b1;
                    ldv_d = {{BYTE_W{1'b0}}, wr_byte};
                end
                ACC_MSB: begin
                    ld_d  = 1'b1;
                    ldv_d = {wr_byte, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    if (wtog_q == WR_FIRST) begin
                        held_d = wr_byte;
                        wtog_d = WR_SECOND;
                    end else begin
                        ld_d   = 1'b1;
                        ldv_d  = {wr_byte, held_q};
                        wtog_d = WR_FIRST;
                    end
                end
                default: ;
            endcase
        end

        if (sf_q) begin
            rd_byte = sv_q;
            if (rd_stb) sf_d = 1'b0;
        end else if (cl_q != CL_EMPTY) begin
            unique case (cl_q)
                CL_LSB: begin
                    rd_byte = clv_q[BYTE_W-1:0];
                    if (rd_stb) cl_d = CL_EMPTY;
                end
                CL_MSB: begin
                    rd_byte = clv_q[CNT_W-1:BYTE_W];
                    if (rd_stb) cl_d = CL_EMPTY;
                end
                CL_WORD: begin
                    rd_byte = clv_q[BYTE_W-1:0];
                    if (rd_stb) cl_d = CL_MSB;
                end
                default: ;
            endcase
        end else begin
            unique case (acc_q)
                ACC_MSB: rd_byte = live_cnt[CNT_W-1:BYTE_W];
                ACC_WORD: begin
                    if (rtog_q == RD_FIRST) begin
                        rd_byte = live_cnt[BYTE_W-1:0];
                        if (rd_stb) rtog_d = RD_SECOND;
                    end else begin
                        rd_byte = live_cnt[CNT_W-1:BYTE_W];
                        if (rd_stb) rtog_d = RD_FIRST;
                    end
                end
                default: rd_byte = live_cnt[BYTE_W-1:0];
            endcase
        end
    end

    assert_msb_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_q == ACC_MSB && !cfg_stb) |=>
            (load_stb && load_val == {$past(wr_byte), {BYTE_W{1'b0}}}));

    assert_word_first_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_q == ACC_WORD && wtog_q == WR_FIRST) |=> !load_stb);

    assert_count_freeze_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_req && cl_q != CL_EMPTY && !rd_stb) |=> $stable(clv_q));

    assert_status_freeze_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_req && sf_q && !rd_stb) |=> $stable(sv_q));

    assert_toggle_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stb |=> (wtog_q == WR_FIRST && rtog_q == RD_FIRST));
endmodule

// File: rtl/tmr_cmd_front.sv
module tmr_cmd_front
    import tmr_regs_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [1:0]             addr,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [BYTE_W-1:0]      rdata,
    input  logic [NCH*CNT_W-1:0]   live_cnt,
    input  logic [NCH-1:0]         live_out,
    output logic [NCH-1:0]         load_stb,
    output logic [NCH*CNT_W-1:0]   load_val,
    output logic [NCH*MODE_W-1:0]  cfg_mode,
    output logic [NCH-1:0]         cfg_bcd
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    logic                 ctl_wr, is_rb;
    logic [1:0]           sel;
    acc_e                 acc_f;
    logic [BYTE_W-1:0]    ch_rd [NCH];

    assign ctl_wr = wr_en && addr == CTL_ADDR;
    assign sel    = wdata[7:6];
    assign is_rb  = sel == 2'd3;
    assign acc_f  = acc_e'(wdata[5:4]);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit, cfg_s, cnt_r, sts_r;
        assign hit   = ctl_wr && !is_rb && sel == 2'(c);
        assign cfg_s = hit && acc_f != ACC_LATCH;
        assign cnt_r = (hit && acc_f == ACC_LATCH) ||
                       (ctl_wr && is_rb && wdata[1+c] && !wdata[5]);
        assign sts_r = ctl_wr && is_rb && wdata[1+c] && !wdata[4];

        tmr_chan_regs u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_stb     (cfg_s),
            .cfg_acc     (acc_f),
            .cfg_mode_in (wdata[3:1]),
            .cfg_bcd_in  (wdata[0]),
            .cnt_req     (cnt_r),
            .sts_req     (sts_r),
            .wr_stb      (wr_en && addr == 2'(c)),
            .rd_stb      (rd_en && addr == 2'(c)),
            .wr_byte     (wdata),
            .live_cnt    (live_cnt[c*CNT_W +: CNT_W]),
            .live_out    (live_out[c]),
            .rd_byte     (ch_rd[c]),
            .load_stb    (load_stb[c]),
            .load_val    (load_val[c*CNT_W +: CNT_W]),
            .mode_q      (cfg_mode[c*MODE_W +: MODE_W]),
            .bcd_q       (cfg_bcd[c])
        );
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++)
            if (addr == 2'(c)) rdata = ch_rd[c];
    end

    assert_single_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    assert_pulse_width_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb != '0) |=> (load_stb & $past(load_stb)) == '0);
endmodule

// File: tb/tmr_cmd_front_tb.sv
module tmr_cmd_front_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] live_v [3];
    logic [2:0]  lout = '0;
    logic [47:0] live_cnt;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  cfg_mode;
    logic [2:0]  cfg_bcd;

    int total = 0, bad = 0;
    bit done = 0;

    int m_acc[3], m_mode[3], m_bcd[3], m_wt[3], m_rt[3], m_held[3];
    int m_cl[3], m_clv[3], m_sf[3], m_sv[3];

    assign live_cnt = {live_v[2], live_v[1], live_v[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .live_out(lout),
        .load_stb(load_stb), .load_val(load_val), .cfg_mode(cfg_mode),
        .cfg_bcd(cfg_bcd)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_wt[c] = 0; m_rt[c] = 0;
            m_held[c] = 0; m_cl[c] = 0; m_clv[c] = 0; m_sf[c] = 0; m_sv[c] = 0;
        end
    endtask

    task automatic freeze_cnt(int c);
        if (m_cl[c] == 0) begin m_cl[c] = m_acc[c]; m_clv[c] = live_v[c]; end
    endtask

    task automatic freeze_sts(int c);
        if (m_sf[c] == 0) begin
            m_sf[c] = 1;
            m_sv[c] = (lout[c] << 7) | (m_acc[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
        end
    endtask

    task automatic model_write(int a, int d, ref int e_stb, ref int e_val[3]);
        int sel, acc;
        if (a == 3) begin
            sel = (d >> 6) & 3; acc = (d >> 4) & 3;
            if (sel == 3) begin
                for (int c = 0; c < 3; c++)
                    if (d[1+c]) begin
                        if (!d[5]) freeze_cnt(c);
                        if (!d[4]) freeze_sts(c);
                    end
            end else if (acc == 0) freeze_cnt(sel);
            else begin
                m_acc[sel] = acc; m_mode[sel] = (d >> 1) & 7; m_bcd[sel] = d & 1;
                m_wt[sel] = 0; m_rt[sel] = 0;
            end
        end else if (m_acc[a] == 1) begin
            e_stb = 1 << a; e_val[a] = d;
        end else if (m_acc[a] == 2) begin
            e_stb = 1 << a; e_val[a] = d << 8;
        end else if (m_wt[a] == 0) begin
            m_held[a] = d; m_wt[a] = 1;
        end else begin
            e_stb = 1 << a; e_val[a] = (d << 8) | m_held[a]; m_wt[a] = 0;
        end
    endtask

    task automatic model_read(int a, output int r);
        r = 0;
        if (a == 3) r = 0;
        else if (m_sf[a]) begin r = m_sv[a]; m_sf[a] = 0; end
        else if (m_cl[a] == 1) begin r = m_clv[a] & 255; m_cl[a] = 0; end
        else if (m_cl[a] == 2) begin r = (m_clv[a] >> 8) & 255; m_cl[a] = 0; end
        else if (m_cl[a] == 3) begin r = m_clv[a] & 255; m_cl[a] = 2; end
        else if (m_acc[a] == 1) r = live_v[a][7:0];
        else if (m_acc[a] == 2) r = live_v[a][15:8];
        else begin
            r = m_rt[a] ? live_v[a][15:8] : live_v[a][7:0];
            m_rt[a] = 1 - m_rt[a];
        end
    endtask

    task automatic check_regs(string tag, int e_stb, int e_val[3]);
        check(load_stb == 3'(e_stb), {tag, " load_stb"}, load_stb, e_stb);
        for (int c = 0; c < 3; c++) begin
            if (e_stb[c])
                check(load_val[c*16 +: 16] == 16'(e_val[c]), {tag, " load_val"},
                      load_val[c*16 +: 16], e_val[c]);
            check(cfg_mode[c*3 +: 3] == 3'(m_mode[c]) && cfg_bcd[c] == 1'(m_bcd[c]),
                  {tag, " cfg"}, {cfg_mode[c*3 +: 3], cfg_bcd[c]}, m_mode[c]*2 + m_bcd[c]);
        end
    endtask

    task automatic op(bit is_rd, int a, int d, string tag);
        int e_stb = 0;
        int e_val[3] = '{0, 0, 0};
        int r;
        @(negedge clk);
        wr_en = !is_rd; rd_en = is_rd; addr = 2'(a); wdata = 8'(d);
        #1;
        if (is_rd) begin
            model_read(a, r);
            check(rdata == 8'(r), {tag, " rdata"}, rdata, r);
        end else model_write(a, d, e_stb, e_val);
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0;
        check_regs(tag, e_stb, e_val);
    endtask

    task automatic wr(int a, int d, string tag); op(0, a, d, tag); endtask
    task automatic rd(int a, string tag); op(1, a, 0, tag); endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e0[3] = '{0, 0, 0};
        live_v[0] = 16'h1A2B; live_v[1] = 16'h3C4D; live_v[2] = 16'h5E6F;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_regs("R1 reset", 0, e0);
        rd(0, "R1 R10 live lo"); rd(0, "R1 R10 live hi");

        // R2 R9 R13: word load on ch0
        wr(3, 8'h34, "R2 ctl ch0 word mode2");
        wr(0, 8'h12, "R9 word first"); wr(0, 8'h56, "R9 R13 word second");
        // LSB-only ch1
        wr(3, 8'h57, "R2 ctl ch1 lsb mode3 bcd");
        wr(1, 8'hAB, "R9 lsb load"); rd(1, "R10 lsb live");
        // MSB-only ch2
        wr(3, 8'hA0, "R2 ctl ch2 msb");
        wr(2, 8'h5C, "R9 msb load"); rd(2, "R10 msb live");

        // R3 R5 R8: word freeze on ch0, second request ignored
        wr(3, 8'h00, "R3 freeze ch0");
        live_v[0] = 16'hBEEF;
        wr(3, 8'h00, "R5 freeze ignored");
        rd(0, "R8 frozen lo"); rd(0, "R8 frozen hi"); rd(0, "R7 live after release");
        rd(0, "R10 live hi");

        // R10 independent toggles
        wr(0, 8'h21, "R10 write first");
        rd(0, "R10 read lo"); rd(0, "R10 read hi");
        wr(0, 8'h43, "R10 R9 write second");

        // R12 restart toggles
        wr(0, 8'h77, "R12 held byte");
        rd(0, "R12 read lo");
        wr(3, 8'h34, "R12 ctl again");
        rd(0, "R12 read lo again");
        wr(0, 8'h11, "R12 first after ctl"); wr(0, 8'h22, "R12 load");

        // R4 R6 R7: read-back all channels, count and status
        wr(3, 8'hCE, "R4 readback all");
        rd(1, "R6 R7 status first"); rd(1, "R7 R8 count lsb"); rd(1, "R7 live");
        rd(2, "R6 status ch2"); rd(2, "R8 count msb");
        rd(0, "R6 status ch0"); rd(0, "R8 cnt lo"); rd(0, "R8 cnt hi");

        // R5 status freeze ignored, R6 output bit
        lout = 3'b100;
        wr(3, 8'hE8, "R4 status ch2 only");
        lout = 3'b000;
        wr(3, 8'hE8, "R5 status ignored");
        rd(2, "R5 R6 old status"); rd(2, "R7 live msb");

        // R4 count-only readback of ch1 leaves ch0 alone
        live_v[1] = 16'h9182;
        wr(3, 8'hD4, "R4 count ch1");
        rd(1, "R4 frozen ch1"); rd(0, "R4 ch0 live");

        // R11 control address read
        rd(3, "R11 ctl read");
        // R3 latch does not touch mode
        wr(3, 8'h40, "R3 mode kept"); rd(1, "R3 frozen");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule